// File: doc/BRIEF.md
# Dual Noise Source Health Monitor

This block watches two raw one-bit entropy streams and flags a seed error when either stream looks broken. Each stream arrives with its own valid strobe. For each stream the monitor keeps a run-length count of identical consecutive bits. It also keeps a count of consecutive identical alternating pairs, where a pair is 01 or 10. A stream that misbehaves alone is allowed long runs. When both streams misbehave at the same time, the monitor trips at half those lengths.

Two outputs are produced. The first is a live error level that follows the present counter values. The second is a one-cycle pulse that marks each rise of that level, so that a sticky flag elsewhere can be set from it. When the enable input is low, every counter, the pair framing and both outputs are cleared.

Top module: `noise_health_mon`

## Requirements
- R1: The error level goes to 1 when either source has delivered more than 64 consecutive valid bits of the same value. A bit that differs from the previous one restarts that source's run count at 1.
- R2: Each source groups its valid bits into non-overlapping pairs. The first pair starts with the first valid bit after enable. The error level goes to 1 when a source has delivered more than 32 consecutive pairs that are all 01, or all 10. Any other pair clears the count. A change from 01 to 10 restarts the count at 1.
- R3: The error level goes to 1 when both sources at the same time have run counts above 32. One source above 32 while the other is not does not raise it.
- R4: The error level goes to 1 when both sources at the same time have pair counts above 16.
- R5: The error level returns to 0 as soon as none of the conditions in R1 to R4 holds. Every result becomes visible after the clock edge that takes the sample.
- R6: The set pulse is high for exactly one cycle. It appears in the same cycle as the 0-to-1 step of the error level, and at no other time.
- R7: While the enable input is 0, all counters and the pair framing are cleared. Both outputs read 0 after the next clock edge.
- R8: Counters saturate at their maximum and never wrap. A constant run of 300 bits keeps the error level at 1.
- R9: A noise bit presented while its valid strobe is 0 is ignored. It neither extends nor breaks a run or a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable; 0 clears all state |
| noise_i | input | 2 | Raw noise bit of source 0 (bit 0) and source 1 (bit 1) |
| valid_i | input | 2 | Per-source strobe qualifying noise_i |
| seed_err_o | output | 1 | Live seed error level |
| seed_err_set_o | output | 1 | One-cycle pulse on the rise of seed_err_o |

## Verification
Counters and outputs are all registered at the same clock edge. The effect of a sample shows one edge after it is presented: the error level, the set pulse and the clearing by enable all follow this one-edge latency. The bench drives inputs a little after each rising edge and reads the outputs just after the following rising edge. Each check therefore sees exactly the consequence of the sample before it. Threshold checks are placed on the sample that reaches the limit and on the one that goes past it.

// File: rtl/nh_pkg.sv
package nh_pkg;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Saturating increment: never exceeds cap.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned cap);
    return (v >= cap) ? cap : v + 1;
  endfunction

  // Strictly above a limit.
  function automatic logic over(input int unsigned v, input int unsigned lim);
    return v > lim;
  endfunction

  // Pair that belongs to an oscillating pattern.
  function automatic logic alt_pair(input logic [1:0] p);
    return (p == 2'b01) || (p == 2'b10);
  endfunction

endpackage

// File: rtl/nh_run_counter.sv
module nh_run_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CNT_MAX = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o
);
  logic             prev_q, prev_d, have_q, have_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_break, run_extend;

  assign run_break  = en_i && valid_i && have_q && (bit_i != prev_q);
  assign run_extend = en_i && valid_i && have_q && (bit_i == prev_q);

  always_comb begin
    cnt_d  = cnt_q;
    prev_d = prev_q;
    have_d = have_q;
    if (!en_i) begin
      cnt_d  = '0;
      prev_d = 1'b0;
      have_d = 1'b0;
    end else if (valid_i) begin
      have_d = 1'b1;
      prev_d = bit_i;
      if (run_extend) cnt_d = CNT_W'(nh_pkg::sat_inc(32'(cnt_q), CNT_MAX));
      else            cnt_d = CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
      have_q <= have_d;
    end
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;

  p_run_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_break |=> (cnt_q == CNT_W'(1)));

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_extend |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/nh_pair_counter.sv
module nh_pair_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CNT_MAX = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_d_o
);
  logic             half_q, half_d, first_q, first_d;
  logic [1:0]       last_q, last_d, pair;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pair_done, pair_alt, pair_repeat;

  assign pair        = {first_q, bit_i};
  assign pair_done   = en_i && valid_i && half_q;
  assign pair_alt    = nh_pkg::alt_pair(pair);
  assign pair_repeat = (cnt_q != '0) && (pair == last_q);

  always_comb begin
    half_d  = half_q;
    first_d = first_q;
    last_d  = last_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      half_d  = 1'b0;
      first_d = 1'b0;
      last_d  = 2'b00;
      cnt_d   = '0;
    end else if (valid_i) begin
      if (!half_q) begin
        half_d  = 1'b1;
        first_d = bit_i;
      end else begin
        half_d = 1'b0;
        last_d = pair;
        if (!pair_alt)        cnt_d = '0;
        else if (pair_repeat) cnt_d = CNT_W'(nh_pkg::sat_inc(32'(cnt_q), CNT_MAX));
        else                  cnt_d = CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 2'b00;
      cnt_q   <= '0;
    end else begin
      half_q  <= half_d;
      first_q <= first_d;
      last_q  <= last_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cnt_d_o = cnt_d;

  p_pair_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_done && !pair_alt) |=> (cnt_q == '0));

  p_first_half_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && !half_q) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/nh_judge.sv
module nh_judge #(
  parameter int unsigned NSRC       = 2,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned RUN_SOLO   = 64,
  parameter int unsigned PAIR_SOLO  = 32,
  parameter int unsigned RUN_BOTH   = 32,
  parameter int unsigned PAIR_BOTH  = 16
) (
  input  logic [NSRC-1:0][CNT_W-1:0] run_cnt_i,
  input  logic [NSRC-1:0][CNT_W-1:0] pair_cnt_i,
  output logic                       fault_o
);
  logic [NSRC-1:0] run_solo, pair_solo, run_both, pair_both;
  logic            solo_hit, joint_hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign run_solo[s]  = nh_pkg::over(32'(run_cnt_i[s]),  RUN_SOLO);
    assign pair_solo[s] = nh_pkg::over(32'(pair_cnt_i[s]), PAIR_SOLO);
    assign run_both[s]  = nh_pkg::over(32'(run_cnt_i[s]),  RUN_BOTH);
    assign pair_both[s] = nh_pkg::over(32'(pair_cnt_i[s]), PAIR_BOTH);
  end

  assign solo_hit  = (|run_solo) || (|pair_solo);
  assign joint_hit = (&run_both) || (&pair_both);
  assign fault_o   = solo_hit || joint_hit;
endmodule

// File: rtl/noise_health_mon.sv
module noise_health_mon #(
  parameter int unsigned RUN_SOLO  = 64,
  parameter int unsigned PAIR_SOLO = 32,
  parameter int unsigned RUN_BOTH  = 32,
  parameter int unsigned PAIR_BOTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] noise_i,
  input  logic [1:0] valid_i,
  output logic       seed_err_o,
  output logic       seed_err_set_o
);
  localparam int unsigned NSRC    = 2;
  localparam int unsigned LIM_MAX = nh_pkg::max2(nh_pkg::max2(RUN_SOLO, PAIR_SOLO),
                                                 nh_pkg::max2(RUN_BOTH, PAIR_BOTH));
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1) + 1;
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [NSRC-1:0][CNT_W-1:0] run_next, run_now, pair_next;
  logic                       fault, err_q, set_q, err_rise;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    nh_run_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) run_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
      .valid_i(valid_i[s]), .bit_i(noise_i[s]),
      .cnt_q_o(run_now[s]), .cnt_d_o(run_next[s])
    );
    nh_pair_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) pair_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
      .valid_i(valid_i[s]), .bit_i(noise_i[s]),
      .cnt_d_o(pair_next[s])
    );
  end

  nh_judge #(
    .NSRC(NSRC), .CNT_W(CNT_W),
    .RUN_SOLO(RUN_SOLO), .PAIR_SOLO(PAIR_SOLO),
    .RUN_BOTH(RUN_BOTH), .PAIR_BOTH(PAIR_BOTH)
  ) judge_i (
    .run_cnt_i(run_next), .pair_cnt_i(pair_next), .fault_o(fault)
  );

  assign err_rise = en_i && fault && !err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      err_q <= en_i && fault;
      set_q <= err_rise;
    end
  end

  assign seed_err_o     = err_q;
  assign seed_err_set_o = set_q;

  p_set_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_err_set_o |-> (seed_err_o && !$past(seed_err_o)));

  p_set_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_err_set_o |=> !seed_err_set_o);

  p_disable_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!seed_err_o && !seed_err_set_o && (run_now == '0)));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (valid_i == 2'b00)) |=> $stable(seed_err_o));
endmodule

// File: tb/noise_health_mon_tb.sv
`timescale 1ns/1ps
module noise_health_mon_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] noise = 2'b00;
  logic [1:0] valid = 2'b00;
  logic       err, set_p;
  int         n_chk = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  noise_health_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .noise_i(noise), .valid_i(valid),
    .seed_err_o(err), .seed_err_set_o(set_p)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One sample: inputs set after an edge, outputs read after the next edge.
  task automatic drive(input logic a, input logic va, input logic b, input logic vb);
    noise = {b, a};
    valid = {vb, va};
    @(posedge clk);
    #2;
  endtask

  function automatic logic filler(input int k);
    return logic'((k >> 1) & 1);
  endfunction

  task automatic restart();
    en = 1'b0;
    valid = 2'b00;
    @(posedge clk);
    #2;
    check("R7 cleared", err, 1'b0);
    en = 1'b1;
  endtask

  task automatic t_reset();
    check("reset err", err, 1'b0);
    check("reset set", set_p, 1'b0);
  endtask

  task automatic t_solo_run();
    restart();
    for (int i = 1; i <= 65; i++) begin
      drive(1'b1, 1'b1, filler(i), 1'b1);
      if (i == 64) check("R1 at limit", err, 1'b0);
    end
    check("R1 over limit", err, 1'b1);
    check("R6 pulse on rise", set_p, 1'b1);
    drive(1'b1, 1'b1, filler(66), 1'b1);
    check("R6 pulse width", set_p, 1'b0);
    check("R1 still high", err, 1'b1);
    drive(1'b0, 1'b1, filler(67), 1'b1);
    check("R5 clears", err, 1'b0);
    check("R6 no pulse on fall", set_p, 1'b0);
  endtask

  task automatic t_gaps();
    restart();
    for (int i = 1; i <= 60; i++) drive(1'b1, 1'b1, filler(i), 1'b1);
    for (int i = 0; i < 10; i++) drive(1'b0, 1'b0, filler(i), 1'b1);
    check("R9 gap ignored", err, 1'b0);
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, filler(i), 1'b1);
    check("R9 run at 64", err, 1'b0);
    drive(1'b1, 1'b1, filler(4), 1'b1);
    check("R9 run at 65", err, 1'b1);
  endtask

  task automatic t_solo_pair();
    restart();
    for (int i = 0; i < 66; i++) begin
      drive(filler(i), 1'b1, logic'(~i[0]), 1'b1);
      if (i == 63) check("R2 32 pairs", err, 1'b0);
      if (i == 64) check("R2 half pair", err, 1'b0);
    end
    check("R2 33 pairs", err, 1'b1);
    check("R6 pulse pair", set_p, 1'b1);
    drive(filler(0), 1'b1, 1'b1, 1'b1);
    check("R2 first bit holds", err, 1'b1);
    drive(filler(1), 1'b1, 1'b1, 1'b1);
    check("R5 pair 11 clears", err, 1'b0);
  endtask

  task automatic t_alternating_pairs();
    logic seen = 1'b0;
    restart();
    for (int i = 0; i < 160; i++) begin
      drive(logic'(i[0] ^ i[1]), 1'b1, filler(i), 1'b1);
      if (err) seen = 1'b1;
    end
    check("R2 01/10 restarts", seen, 1'b0);
  endtask

  task automatic t_joint_run();
    restart();
    for (int i = 1; i <= 40; i++) drive(1'b0, 1'b1, filler(i), 1'b1);
    check("R3 one source only", err, 1'b0);
    restart();
    for (int i = 1; i <= 33; i++) begin
      drive(1'b0, 1'b1, 1'b1, 1'b1);
      if (i == 32) check("R3 both at 32", err, 1'b0);
    end
    check("R3 both at 33", err, 1'b1);
    check("R6 pulse joint", set_p, 1'b1);
  endtask

  task automatic t_joint_pair();
    restart();
    for (int i = 0; i < 34; i++) begin
      drive(i[0], 1'b1, i[0], 1'b1);
      if (i == 31) check("R4 16 pairs", err, 1'b0);
    end
    check("R4 17 pairs", err, 1'b1);
    en = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    check("R7 err low", err, 1'b0);
    check("R7 set low", set_p, 1'b0);
    en = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b1, 1'b1);
    check("R7 counts restarted", err, 1'b0);
  endtask

  task automatic t_saturate();
    restart();
    for (int i = 1; i <= 300; i++) begin
      drive(1'b1, 1'b1, filler(i), 1'b1);
      if (i == 256) check("R8 at 256", err, 1'b1);
    end
    check("R8 at 300", err, 1'b1);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    t_reset();
    t_solo_run();
    t_gaps();
    t_solo_pair();
    t_alternating_pairs();
    t_joint_run();
    t_joint_pair();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule